// File: doc/BRIEF.md
# Framed Serial Command Receiver

This block takes in write-only command words from a three-wire serial link: a serial clock, a data line and an active-low select. All three are resynchronised into the system clock domain, and the block detects the serial clock edges there. Every 24 serial clock rising edges inside a select frame make up one command. The block splits the command into a 16-bit output code, a 4-bit channel number and two mode bits. It then raises a single-cycle write strobe toward the code memory that feeds the output sequencer.

A frame may carry any number of back-to-back commands, and each is committed as its last bit arrives. Two bits of the word are reserved and must be zero. A command with either reserved bit set is rejected. A frame that closes in the middle of a word is also rejected. In both cases the error output pulses. The two mode bits are each ORed with a dedicated pin, so a logic 1 on either side wins. They stay in force until the next accepted command. While the initialisation pass that follows reset is running, serial traffic is ignored. The select level is also passed on, so the sequencer knows a frame is open.

Top module: `cmd_frame_rx`

## Requirements
- R1: Bits arrive most significant first. The first serial clock rising edge after the select falls captures bit 23. Bits 23..8 of the word appear on `wr_code_o` with the strobe.
- R2: Bits 7..4 of the word appear on `wr_addr_o`, where the value n selects channel n (0 to 15).
- R3: `wr_stb_o` is high for exactly one cycle for each accepted 24-bit word. Several words sent in one select frame each produce their own strobe.
- R4: Bit 2 is the immediate-update request and bit 1 the external-clock request. Each is latched from every accepted word. `imm_eff_o` equals `imm_pin_i` OR the latched bit 2, and `xclk_eff_o` equals `xclk_pin_i` OR the latched bit 1. A rejected word leaves the latched bits unchanged.
- R5: A word with bit 3 or bit 0 set to 1 gives no strobe. It pulses `err_o` for one cycle.
- R6: If the select rises after a number of bits that is not a multiple of 24, the partial word is dropped with no strobe and `err_o` pulses.
- R7: Each select falling edge clears the bit counter and the shift register, so a fresh frame always starts at bit 23.
- R8: While `init_busy_i` is high, serial clock edges are ignored. No strobe and no error result.
- R9: `frame_act_o` is high while the synchronised select is low.
- R10: After reset, `wr_stb_o`, `err_o`, `frame_act_o`, `imm_eff_o` and `xclk_eff_o` are low, as long as the mode pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_sel_n_i | input | 1 | Active-low frame select, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| init_busy_i | input | 1 | Initialisation pass in progress; serial input ignored |
| imm_pin_i | input | 1 | Immediate-update mode pin |
| xclk_pin_i | input | 1 | External sequencer clock select pin |
| wr_stb_o | output | 1 | One-cycle write strobe to code memory |
| wr_addr_o | output | 4 | Channel address of the write |
| wr_code_o | output | 16 | Output code of the write |
| imm_eff_o | output | 1 | Effective immediate-update mode |
| xclk_eff_o | output | 1 | Effective external-clock select |
| frame_act_o | output | 1 | Select frame open |
| err_o | output | 1 | One-cycle pulse on a rejected or partial word |

## Verification
Assertions check on every cycle that the strobe never lasts longer than one cycle and never coincides with an error. They also check that a select falling edge leaves the counter at zero, that nothing is committed while initialisation runs, and that the latched mode bits move only on an accepted word. Only the bench scenarios can show that the field boundaries are correct. It sweeps every channel against every mode-pin combination and checks the OR rule. It also sends multi-word frames, truncated frames and words with a reserved bit set, each of which must produce the right number of strobes and error pulses.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;
  // trailing control field: reserved, immediate, ext-clock, fill
  localparam int CTRL_W   = 4;
  localparam int RSV_HI   = 3;
  localparam int IMM_BIT  = 2;
  localparam int XCLK_BIT = 1;
  localparam int RSV_LO   = 0;
endpackage

// File: rtl/cmdrx_sync.sv
module cmdrx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/cmdrx_shifter.sv
module cmdrx_shifter #(
  parameter int WORD_W = 24,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              seln_s,
  input  logic              sdat_s,
  input  logic              busy_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic              partial_o,
  output logic              act_o
);
  logic              sclk_q, seln_q;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;
  logic sel_fall, sel_rise, bit_take;

  assign sel_fall = seln_q & ~seln_s;
  assign sel_rise = ~seln_q & seln_s;
  assign bit_take = sclk_s & ~sclk_q & ~seln_s & ~busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= 1'b0;
      seln_q    <= 1'b1;
      cnt       <= '0;
      shreg     <= '0;
      done_o    <= 1'b0;
      word_o    <= '0;
      partial_o <= 1'b0;
      act_o     <= 1'b0;
    end else begin
      sclk_q    <= sclk_s;
      seln_q    <= seln_s;
      act_o     <= ~seln_s;
      done_o    <= 1'b0;
      partial_o <= 1'b0;
      if (sel_fall) begin
        cnt   <= '0;
        shreg <= '0;
      end else if (bit_take) begin
        shreg <= {shreg[WORD_W-2:0], sdat_s};
        if (cnt == CNT_W'(WORD_W - 1)) begin
          cnt    <= '0;
          done_o <= 1'b1;
          word_o <= {shreg[WORD_W-2:0], sdat_s};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (sel_rise && cnt != '0 && !busy_i) begin
        partial_o <= 1'b1;
        cnt       <= '0;
      end
    end
  end

  AST_CLR_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    sel_fall |=> (cnt == '0)); // R7
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> (!done_o && !partial_o)); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(WORD_W)); // R6
endmodule

// File: rtl/cmdrx_decode.sv
module cmdrx_decode
  import cmdrx_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int ADDR_W = 4,
  localparam int WORD_W = CODE_W + ADDR_W + CTRL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              partial_i,
  input  logic              imm_pin_i,
  input  logic              xclk_pin_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [CODE_W-1:0] wr_code_o,
  output logic              imm_eff_o,
  output logic              xclk_eff_o,
  output logic              err_o
);
  logic rsv_bad, accept, imm_q, xclk_q, imm_nx, xclk_nx;

  assign rsv_bad = word_i[RSV_HI] | word_i[RSV_LO];
  assign accept  = done_i & ~rsv_bad;
  assign imm_nx  = accept ? word_i[IMM_BIT]  : imm_q;
  assign xclk_nx = accept ? word_i[XCLK_BIT] : xclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb_o   <= 1'b0;
      wr_addr_o  <= '0;
      wr_code_o  <= '0;
      imm_q      <= 1'b0;
      xclk_q     <= 1'b0;
      imm_eff_o  <= 1'b0;
      xclk_eff_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      wr_stb_o   <= accept;
      err_o      <= (done_i & rsv_bad) | partial_i;
      imm_q      <= imm_nx;
      xclk_q     <= xclk_nx;
      imm_eff_o  <= imm_pin_i | imm_nx;
      xclk_eff_o <= xclk_pin_i | xclk_nx;
      if (accept) begin
        wr_addr_o <= word_i[CTRL_W +: ADDR_W];
        wr_code_o <= word_i[CTRL_W + ADDR_W +: CODE_W];
      end
    end
  end

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |=> !wr_stb_o); // R3
  AST_STB_NOT_ERR: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb_o && err_o)); // R5
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(imm_q) && $stable(xclk_q))); // R4
endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx
  import cmdrx_pkg::*;
#(
  parameter int CODE_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_sel_n_i,
  input  logic              ser_dat_i,
  input  logic              init_busy_i,
  input  logic              imm_pin_i,
  input  logic              xclk_pin_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [CODE_W-1:0] wr_code_o,
  output logic              imm_eff_o,
  output logic              xclk_eff_o,
  output logic              frame_act_o,
  output logic              err_o
);
  localparam int WORD_W = CODE_W + ADDR_W + CTRL_W;

  logic [2:0]        pins_s;
  logic              done;
  logic              partial;
  logic [WORD_W-1:0] word;

  cmdrx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({ser_clk_i, ser_sel_n_i, ser_dat_i}),
    .q_o(pins_s)
  );

  cmdrx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst),
    .sclk_s(pins_s[2]), .seln_s(pins_s[1]), .sdat_s(pins_s[0]),
    .busy_i(init_busy_i),
    .done_o(done), .word_o(word), .partial_o(partial), .act_o(frame_act_o)
  );

  cmdrx_decode #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst),
    .done_i(done), .word_i(word), .partial_i(partial),
    .imm_pin_i(imm_pin_i), .xclk_pin_i(xclk_pin_i),
    .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o), .wr_code_o(wr_code_o),
    .imm_eff_o(imm_eff_o), .xclk_eff_o(xclk_eff_o), .err_o(err_o)
  );

  AST_FRAME_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && !pins_s[1] |=> frame_act_o); // R9
endmodule

// File: tb/sim_cmd_frame_rx.sv
module sim_cmd_frame_rx;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, seln = 1'b1, sdat = 1'b0, busy = 1'b0, ipin = 1'b0, xpin = 1'b0;
  logic wr_stb, imm_eff, xclk_eff, fact, err;
  logic [3:0]  wr_addr;
  logic [15:0] wr_code;

  int n_chk = 0, n_bad = 0, stb_cnt = 0, err_cnt = 0;
  logic [3:0]  cap_addr;
  logic [15:0] cap_code;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  cmd_frame_rx u0 (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_sel_n_i(seln), .ser_dat_i(sdat),
    .init_busy_i(busy), .imm_pin_i(ipin), .xclk_pin_i(xpin),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_code_o(wr_code),
    .imm_eff_o(imm_eff), .xclk_eff_o(xclk_eff), .frame_act_o(fact), .err_o(err)
  );

  always @(negedge clk) begin
    if (!rst && wr_stb) begin
      stb_cnt++;
      cap_addr = wr_addr;
      cap_code = wr_code;
    end
    if (!rst && err) err_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_frame();
    seln = 1'b0;
    wclk(5);
  endtask

  task automatic close_frame();
    wclk(4);
    seln = 1'b1;
    wclk(8);
  endtask

  task automatic shift_bits(input logic [23:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sdat = w[23-i];
      wclk(3);
      sclk = 1'b1;
      wclk(3);
      sclk = 1'b0;
    end
  endtask

  function automatic logic [23:0] mk(input logic [15:0] c, input logic [3:0] a,
                                      input bit r3, input bit c1, input bit c0, input bit r0);
    return {c, a, r3, c1, c0, r0};
  endfunction

  initial begin
    int s0, e0;
    wclk(4);
    rst = 1'b0;
    wclk(2);
    // R10 reset state
    chk(!wr_stb && !err && !fact && !imm_eff && !xclk_eff, "R10 reset outputs",
        {wr_stb, err, fact, imm_eff, xclk_eff}, 0);

    // R9 frame activity
    open_frame();
    chk(fact == 1'b1, "R9 frame_act in frame", fact, 1);
    close_frame();
    chk(fact == 1'b0, "R9 frame_act idle", fact, 0);

    // R1 R2 R4: sweep all channels against all pin combinations
    for (int a = 0; a < 16; a++) begin
      for (int pm = 0; pm < 4; pm++) begin
        logic [15:0] c;
        bit c1, c0;
        c  = 16'(a * 16'h1111) ^ 16'(pm * 16'h0F0F) ^ 16'hA5C3;
        c1 = a[0];
        c0 = a[1] ^ pm[0];
        ipin = pm[1];
        xpin = pm[0];
        s0 = stb_cnt;
        open_frame();
        shift_bits(mk(c, 4'(a), 0, c1, c0, 0), 24);
        close_frame();
        chk(stb_cnt == s0 + 1, "R3 one strobe per word", stb_cnt - s0, 1);
        chk(cap_code == c, "R1 code field", cap_code, c);
        chk(cap_addr == 4'(a), "R2 address field", cap_addr, a);
        chk({imm_eff, xclk_eff} == {pm[1] | c1, pm[0] | c0}, "R4 effective modes",
            {imm_eff, xclk_eff}, {pm[1] | c1, pm[0] | c0});
      end
    end
    ipin = 0; xpin = 0;
    wclk(3);
    // last sweep word a=15,pm=3 -> c1=1, c0=0; pins now low
    chk({imm_eff, xclk_eff} == 2'b10, "R4 latched bits persist", {imm_eff, xclk_eff}, 2'b10);
    ipin = 0; xpin = 1;
    wclk(3);
    chk({imm_eff, xclk_eff} == 2'b11, "R4 pin OR latched", {imm_eff, xclk_eff}, 2'b11);
    xpin = 0;

    // R3 three words in one frame
    s0 = stb_cnt;
    open_frame();
    shift_bits(mk(16'h1234, 4'd3, 0, 0, 0, 0), 24);
    shift_bits(mk(16'hBEEF, 4'd9, 0, 0, 1, 0), 24);
    shift_bits(mk(16'h0F2C, 4'd12, 0, 0, 0, 0), 24);
    close_frame();
    chk(stb_cnt == s0 + 3, "R3 multi-word frame strobes", stb_cnt - s0, 3);
    chk(cap_addr == 4'd12 && cap_code == 16'h0F2C, "R3 last word of frame",
        {cap_addr, cap_code}, {4'd12, 16'h0F2C});
    chk({imm_eff, xclk_eff} == 2'b00, "R4 control resent each word", {imm_eff, xclk_eff}, 0);

    // R5 reserved bits
    s0 = stb_cnt; e0 = err_cnt;
    open_frame();
    shift_bits(mk(16'h5555, 4'd1, 1, 1, 1, 0), 24);
    close_frame();
    chk(stb_cnt == s0 && err_cnt == e0 + 1, "R5 bit3 set rejected",
        {stb_cnt - s0, err_cnt - e0}, {32'd0, 32'd1});
    s0 = stb_cnt; e0 = err_cnt;
    open_frame();
    shift_bits(mk(16'h6666, 4'd2, 0, 1, 1, 1), 24);
    close_frame();
    chk(stb_cnt == s0 && err_cnt == e0 + 1, "R5 bit0 set rejected",
        {stb_cnt - s0, err_cnt - e0}, {32'd0, 32'd1});
    chk({imm_eff, xclk_eff} == 2'b00, "R4 rejected word keeps modes", {imm_eff, xclk_eff}, 0);

    // R6 partial word, then R7 fresh frame aligned
    s0 = stb_cnt; e0 = err_cnt;
    open_frame();
    shift_bits(24'hFFFFFF, 10);
    close_frame();
    chk(stb_cnt == s0 && err_cnt == e0 + 1, "R6 partial dropped",
        {stb_cnt - s0, err_cnt - e0}, {32'd0, 32'd1});
    s0 = stb_cnt;
    open_frame();
    shift_bits(mk(16'h8001, 4'd6, 0, 0, 0, 0), 24);
    close_frame();
    chk(stb_cnt == s0 + 1 && cap_code == 16'h8001 && cap_addr == 4'd6,
        "R7 frame restarts at bit 23", {cap_addr, cap_code}, {4'd6, 16'h8001});

    // R6 word plus trailing partial in one frame
    s0 = stb_cnt; e0 = err_cnt;
    open_frame();
    shift_bits(mk(16'h4321, 4'd7, 0, 0, 0, 0), 24);
    shift_bits(24'h0, 5);
    close_frame();
    chk(stb_cnt == s0 + 1 && err_cnt == e0 + 1, "R6 word then partial",
        {stb_cnt - s0, err_cnt - e0}, {32'd1, 32'd1});

    // R8 busy ignores input
    busy = 1'b1;
    s0 = stb_cnt; e0 = err_cnt;
    open_frame();
    shift_bits(mk(16'h7777, 4'd5, 0, 1, 1, 0), 24);
    shift_bits(24'h0, 3);
    close_frame();
    busy = 1'b0;
    wclk(3);
    chk(stb_cnt == s0 && err_cnt == e0, "R8 busy ignores serial",
        {stb_cnt - s0, err_cnt - e0}, 0);
    chk({imm_eff, xclk_eff} == 2'b00, "R8 busy leaves modes", {imm_eff, xclk_eff}, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule